// File: doc/BRIEF.md
# Credit-Reporting Reservation Station

This block holds instructions for one functional unit of an out-of-order core until their source operands are known. Each instruction arrives on the issue port with an opcode, a destination tag, and for each of its two sources either a value or the tag of the result it is waiting for. The station watches the result broadcast bus. When a completing tag matches a waiting source, it copies the value into that source. An entry whose two sources are both present is ready and can be sent to the functional unit on the dispatch port.

The issue side needs no full flag. Every cycle the station drives a registered count of its empty slots. Issue logic may present an instruction only while that count is nonzero, and the station ignores anything presented while it is zero. When several entries are ready at once, the one allocated earliest goes first. Age is tracked with a wrapping allocation sequence number.

Top module: `rsv_station`

## Requirements
- R1: After reset, `free_cnt` equals ENTRIES and `disp_valid` is low.
- R2: `free_cnt` is a register. After a clock edge it equals the number of unoccupied slots: one lower after an accepted issue and one higher after a taken dispatch (`disp_valid` and `disp_ready` both high).
- R3: An issue presented while `free_cnt` is zero has no effect. No entry is written, `free_cnt` stays zero unless a dispatch is taken, and that instruction is never dispatched.
- R4: An instruction issued with both sources marked present is offered on the dispatch port in the cycle after the issue edge, carrying the issued opcode, destination tag and values.
- R5: A waiting source whose tag equals `bc_tag` while `bc_valid` is high takes `bc_val`. The entry is offered on the dispatch port in the cycle after the broadcast edge.
- R6: A broadcast whose tag matches a waiting source of the instruction being issued in that same cycle is captured, and is not lost.
- R7: When several entries are ready, the one allocated earliest is dispatched first, regardless of which slot holds it.
- R8: `disp_valid` is high only while some entry has both sources present. A ready entry that is offered but not taken stays offered.
- R9: A broadcast whose tag matches no waiting source changes no stored operand.
- R10: Two sources of one entry that wait on the same tag are both filled by a single broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request; honoured only while free_cnt is nonzero |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_dst | input | TAG_W | Destination tag |
| iss_a_rdy | input | 1 | Source A value present |
| iss_a_tag | input | TAG_W | Source A tag to wait on |
| iss_a_val | input | DATA_W | Source A value |
| iss_b_rdy | input | 1 | Source B value present |
| iss_b_tag | input | TAG_W | Source B tag to wait on |
| iss_b_val | input | DATA_W | Source B value |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| disp_ready | input | 1 | Functional unit accepts the offered entry |
| disp_valid | output | 1 | A ready entry is offered |
| disp_op | output | OP_W | Opcode of the offered entry |
| disp_dst | output | TAG_W | Destination tag of the offered entry |
| disp_a | output | DATA_W | Source A value of the offered entry |
| disp_b | output | DATA_W | Source B value of the offered entry |
| free_cnt | output | $clog2(ENTRIES+1) | Registered count of empty slots |

## Verification
Operand capture and allocation can happen in the same cycle: an instruction is issued with a source still waiting while the result it waits on is broadcast. The bench drives both in one cycle. It then requires that the entry is offered in the next cycle carrying the broadcast value. A second collision is between a taken dispatch and the age order. A slot freed by dispatch is refilled, and the bench requires that the older entry in the higher slot still leaves before the new one.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic { SRC_WAIT = 1'b0, SRC_HAVE = 1'b1 } src_state_e;

  function automatic src_state_e src_next(input src_state_e cur, input logic live,
                                          input logic hit);
    if (live && cur == SRC_WAIT && hit) return SRC_HAVE;
    return cur;
  endfunction
endpackage

// File: rtl/rsv_operand.sv
module rsv_operand import rsv_pkg::*; #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              live,
  input  logic              in_rdy,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              have,
  output logic [DATA_W-1:0] val
);
  src_state_e        st_q, st_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [DATA_W-1:0] val_q, val_n;
  logic              hit_new, hit_old, data_en;

  assign hit_new = bc_valid && (bc_tag == in_tag);
  assign hit_old = bc_valid && (bc_tag == tag_q);

  always_comb begin
    st_n    = st_q;
    tag_n   = tag_q;
    val_n   = val_q;
    data_en = 1'b0;
    if (load) begin
      data_en = 1'b1;
      tag_n   = in_tag;
      st_n    = (in_rdy || hit_new) ? SRC_HAVE : SRC_WAIT;
      val_n   = in_rdy ? in_val : bc_val;
    end else begin
      st_n = src_next(st_q, live, hit_old);
      if (st_n != st_q) begin
        data_en = 1'b1;
        val_n   = bc_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SRC_WAIT;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      tag_q <= tag_n;
      val_q <= val_n;
    end
  end

  assign have = (st_q == SRC_HAVE);
  assign val  = val_q;
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry #(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int SEQ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              clear,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic              in_a_rdy,
  input  logic [TAG_W-1:0]  in_a_tag,
  input  logic [DATA_W-1:0] in_a_val,
  input  logic              in_b_rdy,
  input  logic [TAG_W-1:0]  in_b_tag,
  input  logic [DATA_W-1:0] in_b_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dst,
  output logic [SEQ_W-1:0]  seq,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b
);
  logic              busy_q, busy_n;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dst_q;
  logic [SEQ_W-1:0]  seq_q;
  logic              a_have, b_have;

  always_comb begin
    busy_n = busy_q;
    if (alloc)      busy_n = 1'b1;
    else if (clear) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_n;
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      op_q  <= in_op;
      dst_q <= in_dst;
      seq_q <= in_seq;
    end
  end

  rsv_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) src_a_i (
    .clk(clk), .rst_n(rst_n), .load(alloc), .live(busy_q),
    .in_rdy(in_a_rdy), .in_tag(in_a_tag), .in_val(in_a_val),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .have(a_have), .val(a));

  rsv_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) src_b_i (
    .clk(clk), .rst_n(rst_n), .load(alloc), .live(busy_q),
    .in_rdy(in_b_rdy), .in_tag(in_b_tag), .in_val(in_b_val),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .have(b_have), .val(b));

  assign busy  = busy_q;
  assign ready = busy_q && a_have && b_have;
  assign op    = op_q;
  assign dst   = dst_q;
  assign seq   = seq_q;
endmodule

// File: rtl/rsv_pick.sv
module rsv_pick_free #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0] busy,
  output logic         found,
  output logic [N-1:0] grant
);
  always_comb begin
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

module rsv_pick_oldest #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int SEQ_W = 3
) (
  input  logic [N-1:0]            ready,
  input  logic [N-1:0][SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]        next_seq,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  logic [SEQ_W-1:0] best_age, age;
  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_age = '0;
    age      = '0;
    for (int i = 0; i < N; i++) begin
      age = next_seq - seq[i];
      if (ready[i] && (!found || age > best_age)) begin
        found    = 1'b1;
        best_age = age;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rsv_station.sv
module rsv_station #(
  parameter int ENTRIES = 4,
  parameter int OP_W    = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SEQ_W  = IDX_W + 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              iss_a_rdy,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic              iss_b_rdy,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [TAG_W-1:0]  disp_dst,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [CNT_W-1:0]  free_cnt
);
  logic [ENTRIES-1:0]             busy, ready, alloc_oh, clear_oh, busy_nxt;
  logic [ENTRIES-1:0][OP_W-1:0]   e_op;
  logic [ENTRIES-1:0][TAG_W-1:0]  e_dst;
  logic [ENTRIES-1:0][SEQ_W-1:0]  e_seq;
  logic [ENTRIES-1:0][DATA_W-1:0] e_a, e_b;
  logic [SEQ_W-1:0]               seq_q, seq_n;
  logic [CNT_W-1:0]               cnt_q, cnt_n;
  logic                           accept, slot_found, sel_found, fire;
  logic [ENTRIES-1:0]             slot_oh;
  logic [IDX_W-1:0]               sel_idx;

  assign accept = iss_valid && (cnt_q != '0) && slot_found;
  assign fire   = sel_found && disp_ready;

  rsv_pick_free #(.N(ENTRIES), .IDX_W(IDX_W)) free_i (
    .busy(busy), .found(slot_found), .grant(slot_oh));

  rsv_pick_oldest #(.N(ENTRIES), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) age_i (
    .ready(ready), .seq(e_seq), .next_seq(seq_q),
    .found(sel_found), .idx(sel_idx));

  always_comb begin
    alloc_oh = accept ? slot_oh : '0;
    clear_oh = '0;
    if (fire) clear_oh[sel_idx] = 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    rsv_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) ent_i (
      .clk(clk), .rst_n(rst_n), .alloc(alloc_oh[g]), .clear(clear_oh[g]),
      .in_op(iss_op), .in_dst(iss_dst), .in_seq(seq_q),
      .in_a_rdy(iss_a_rdy), .in_a_tag(iss_a_tag), .in_a_val(iss_a_val),
      .in_b_rdy(iss_b_rdy), .in_b_tag(iss_b_tag), .in_b_val(iss_b_val),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .busy(busy[g]), .ready(ready[g]), .op(e_op[g]), .dst(e_dst[g]),
      .seq(e_seq[g]), .a(e_a[g]), .b(e_b[g]));
    assign busy_nxt[g] = alloc_oh[g] || (busy[g] && !clear_oh[g]);
  end

  always_comb begin
    seq_n = seq_q;
    if (accept) seq_n = seq_q + 1'b1;
    cnt_n = CNT_W'(ENTRIES);
    for (int i = 0; i < ENTRIES; i++) begin
      if (busy_nxt[i]) cnt_n = cnt_n - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      cnt_q <= CNT_W'(ENTRIES);
    end else begin
      seq_q <= seq_n;
      cnt_q <= cnt_n;
    end
  end

  assign disp_valid = sel_found;
  assign disp_op    = e_op[sel_idx];
  assign disp_dst   = e_dst[sel_idx];
  assign disp_a     = e_a[sel_idx];
  assign disp_b     = e_b[sel_idx];
  assign free_cnt   = cnt_q;
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             disp_ready,
  input logic             disp_valid,
  input logic [CNT_W-1:0] free_cnt
);
  logic acc, tak;
  assign acc = iss_valid && (free_cnt != '0);
  assign tak = disp_valid && disp_ready;

  // R2
  free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) <= ENTRIES);

  // R2
  free_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(free_cnt) == int'($past(free_cnt)) - int'($past(acc)) + int'($past(tak)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0 && !tak) |=> free_cnt == '0);

  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> disp_valid);

  // R8
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) == ENTRIES) |-> !disp_valid);
endmodule

bind rsv_station rsv_station_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .disp_ready(disp_ready),
  .disp_valid(disp_valid), .free_cnt(free_cnt));

// File: tb/rsv_station_tb.sv
module rsv_station_tb_top;
  localparam int ENTRIES = 4;
  localparam int CNT_W   = $clog2(ENTRIES + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_a_rdy, iss_b_rdy, bc_valid, disp_ready;
  logic [3:0]  iss_op, iss_dst, iss_a_tag, iss_b_tag, bc_tag;
  logic [15:0] iss_a_val, iss_b_val, bc_val;
  logic        disp_valid;
  logic [3:0]  disp_op, disp_dst;
  logic [15:0] disp_a, disp_b;
  logic [CNT_W-1:0] free_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rsv_station dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .disp_ready(disp_ready),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_a(disp_a), .disp_b(disp_b), .free_cnt(free_cnt));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input int op, input int dst, input bit ar, input int at, input int av,
                       input bit br, input int bt, input int bv,
                       input bit bcv = 0, input int bct = 0, input int bcd = 0);
    @(negedge clk);
    iss_valid = 1; iss_op = 4'(op); iss_dst = 4'(dst);
    iss_a_rdy = ar; iss_a_tag = 4'(at); iss_a_val = 16'(av);
    iss_b_rdy = br; iss_b_tag = 4'(bt); iss_b_val = 16'(bv);
    bc_valid = bcv; bc_tag = 4'(bct); bc_val = 16'(bcd);
    @(posedge clk); #1;
    iss_valid = 0; bc_valid = 0;
  endtask

  task automatic bcast(input int tag, input int val);
    @(negedge clk);
    bc_valid = 1; bc_tag = 4'(tag); bc_val = 16'(val);
    @(posedge clk); #1;
    bc_valid = 0;
  endtask

  task automatic take(input string req, input int op, input int a, input int b);
    @(negedge clk);
    disp_ready = 1;
    #1;
    chk(req, "disp_valid", disp_valid, 1);
    chk(req, "disp_op", disp_op, op);
    chk(req, "disp_a", disp_a, a);
    chk(req, "disp_b", disp_b, b);
    @(posedge clk); #1;
    disp_ready = 0;
  endtask

  task automatic t_reset;
    chk("R1", "free_cnt", free_cnt, ENTRIES);
    chk("R1", "disp_valid", disp_valid, 0);
  endtask

  task automatic t_ready_issue;
    issue(1, 2, 1, 0, 5, 1, 0, 7);
    chk("R4", "disp_valid", disp_valid, 1);
    chk("R2", "free_cnt after issue", free_cnt, ENTRIES - 1);
    chk("R4", "disp_dst", disp_dst, 2);
    take("R4", 1, 5, 7);
    chk("R2", "free_cnt after dispatch", free_cnt, ENTRIES);
  endtask

  task automatic t_wakeup;
    issue(2, 3, 0, 3, 0, 1, 0, 9);
    chk("R8", "waiting entry not offered", disp_valid, 0);
    bcast(6, 11);
    chk("R9", "unmatched broadcast", disp_valid, 0);
    bcast(3, 20);
    chk("R5", "woken entry offered", disp_valid, 1);
    @(negedge clk); #1;
    chk("R8", "held while not taken", disp_valid, 1);
    take("R5_R9", 2, 20, 9);
  endtask

  task automatic t_same_cycle;
    issue(3, 4, 0, 4, 0, 1, 0, 1, 1, 4, 33);
    chk("R6", "capture at issue", disp_valid, 1);
    take("R6", 3, 33, 1);
  endtask

  task automatic t_shared_tag;
    issue(5, 1, 0, 8, 0, 0, 8, 0);
    bcast(8, 44);
    take("R10", 5, 44, 44);
  endtask

  task automatic t_oldest;
    issue(4, 0, 1, 0, 1, 1, 0, 2);
    issue(5, 0, 1, 0, 3, 1, 0, 4);
    take("R7", 4, 1, 2);
    issue(6, 0, 1, 0, 5, 1, 0, 6);
    take("R7 older slot1 first", 5, 3, 4);
    take("R7", 6, 5, 6);
    chk("R2", "free_cnt empty", free_cnt, ENTRIES);
  endtask

  task automatic t_full;
    for (int i = 0; i < ENTRIES; i++) issue(7 + i, i, 0, 9, 0, 1, 0, i);
    chk("R2", "free_cnt full", free_cnt, 0);
    issue(15, 9, 1, 0, 99, 1, 0, 98);
    chk("R3", "free_cnt stays zero", free_cnt, 0);
    chk("R3", "ignored issue not offered", disp_valid, 0);
    bcast(9, 1);
    for (int i = 0; i < ENTRIES; i++) take("R3_R7", 7 + i, 1, i);
    chk("R3", "no ghost entry", disp_valid, 0);
    chk("R3", "free_cnt restored", free_cnt, ENTRIES);
  endtask

  initial begin
    rst_n = 0; iss_valid = 0; bc_valid = 0; disp_ready = 0;
    iss_op = 0; iss_dst = 0; iss_a_rdy = 0; iss_a_tag = 0; iss_a_val = 0;
    iss_b_rdy = 0; iss_b_tag = 0; iss_b_val = 0; bc_tag = 0; bc_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_ready_issue;
    t_wakeup;
    t_same_cycle;
    t_shared_tag;
    t_oldest;
    t_full;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule